// File: doc/BRIEF.md
# Burst-Write Single-Drain Queue

This block is a synchronous queue. In any clock cycle a producer may offer a group of up to `LANES` data words on a packed lane vector, together with a count of how many lanes are valid. The consumer sees at most one word per cycle: the current head of the stored queue, with a flag that says whether a word is present. The producer cannot be stalled and the consumer has no read enable. While the queue holds data, it advances by one word on every clock edge.

The output depends only on stored state. A word that is written therefore becomes visible one cycle later at the earliest. When the queue is empty at an edge, the incoming group becomes the whole contents and nothing is removed. The first lane of that group is then the next word shown. When the queue already holds data, the group is appended behind the existing words and the head is removed in the same edge. Storage is bounded by `DEPTH`. Incoming words that do not fit are discarded, and a sticky flag records the loss until reset.

Top module: `fbq_top`

## Requirements
- R1: One cycle after a clock edge with `rst` high, `fill_level` is 0, `head_vld` is 0 and `ovf_sticky` is 0.
- R2: `head_vld` is 1 exactly when `fill_level` is non-zero. `head_data` shows the oldest stored word and reads 0 while `head_vld` is 0.
- R3: If `fill_level` is 0 at an edge, every accepted lane of the group is stored and no word is removed. After the edge, `head_data` equals lane 0 of that group and `fill_level` equals the accepted count.
- R4: If `fill_level` is non-zero at an edge, the accepted lanes are appended and the head is removed. After the edge, `fill_level` equals the old level plus the accepted count minus one.
- R5: Within a group, words enter the queue in lane order. Lane i occupies bits `[i*DW +: DW]` of `grp_data`, and lane 0 goes first. Words leave in the order they entered.
- R6: A word offered in a cycle is not visible on `head_vld`/`head_data` before the next clock edge.
- R7: A `grp_cnt` value above `LANES` is treated as `LANES`.
- R8: Free room is `DEPTH - fill_level`, taken before the same-edge removal. If the effective count exceeds the free room, only the lowest-numbered lanes that fit are stored. The rest are dropped and `ovf_sticky` rises and stays high until reset. A group that exactly fits sets no flag.
- R9: `fill_level` is `$clog2(DEPTH+1)` bits wide and never exceeds `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_data | input | LANES*DW | Packed incoming lanes, lane 0 in the low bits |
| grp_cnt | input | $clog2(LANES+1) | Number of valid lanes this cycle |
| head_vld | output | 1 | A stored word is present |
| head_data | output | DW | Oldest stored word, 0 when absent |
| fill_level | output | $clog2(DEPTH+1) | Number of stored words |
| ovf_sticky | output | 1 | Set when words were dropped; cleared by reset |

## Verification
All four outputs are functions of the registered state. Their value after an edge therefore reflects the group driven in the cycle before that edge: the latency is exactly one cycle for the head flag, the head word, the level and the overflow flag. The bench drives each group just after a falling edge. It compares all outputs against a reference queue at the following falling edge, once the model has applied the previous group. A separate probe, 1 ns after driving a group into an empty queue, confirms that nothing shows before the edge.

// File: rtl/fbq_pkg.sv
package fbq_pkg;

    // What the queue does with the incoming group at a clock edge.
    typedef enum logic {
        EDGE_LOAD,   // queue empty: group becomes contents, no removal
        EDGE_SHIFT   // queue holds data: append group, remove head
    } edge_act_e;

    function automatic logic [31:0] clip_u(input logic [31:0] a, input logic [31:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [31:0] ring_add(input logic [31:0] base,
                                             input logic [31:0] off,
                                             input logic [31:0] depth);
        return (base + off) % depth;
    endfunction

endpackage

// File: rtl/fbq_admit.sv
module fbq_admit
    import fbq_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 8,
    parameter int LCW   = 3,
    parameter int CW    = 4
) (
    input  logic [LCW-1:0] req_cnt,
    input  logic [CW-1:0]  fill,
    output logic [LCW-1:0] take,
    output logic           drop
);
    logic [31:0] eff;
    logic [31:0] room;

    always_comb begin
        eff  = clip_u(32'(req_cnt), 32'(LANES));
        room = 32'(DEPTH) - 32'(fill);
        take = LCW'(clip_u(eff, room));
        drop = (eff > room);
    end
endmodule

// File: rtl/fbq_ring.sv
module fbq_ring
    import fbq_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    parameter int PW    = 3,
    parameter int LCW   = 3
) (
    input  logic                clk,
    input  logic [PW-1:0]       wr_base,
    input  logic [LCW-1:0]      take,
    input  logic [LANES*DW-1:0] lanes,
    input  logic [PW-1:0]       head_idx,
    output logic [DW-1:0]       head_word
);
    logic [DW-1:0] cells [DEPTH];
    logic [LANES-1:0] wen;
    logic [PW-1:0]    waddr [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wen[g]   = (32'(take) > 32'(g));
        assign waddr[g] = PW'(ring_add(32'(wr_base), 32'(g), 32'(DEPTH)));
    end

    // Accepted lanes never exceed DEPTH, so their addresses are distinct.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (wen[i]) cells[waddr[i]] <= lanes[i*DW +: DW];
        end
    end

    assign head_word = cells[head_idx];
endmodule

// File: rtl/fbq_ctrl.sv
module fbq_ctrl
    import fbq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PW    = 3,
    parameter int CW    = 4,
    parameter int LCW   = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [LCW-1:0] take,
    input  logic           drop,
    output logic [PW-1:0]  wr_ptr,
    output logic [PW-1:0]  rd_ptr,
    output logic [CW-1:0]  fill,
    output logic           ovf
);
    edge_act_e   act;
    logic [31:0] pop_n;

    always_comb begin
        act   = (fill == '0) ? EDGE_LOAD : EDGE_SHIFT;
        pop_n = (act == EDGE_SHIFT) ? 32'd1 : 32'd0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
            ovf    <= 1'b0;
        end else begin
            wr_ptr <= PW'(ring_add(32'(wr_ptr), 32'(take), 32'(DEPTH)));
            rd_ptr <= PW'(ring_add(32'(rd_ptr), pop_n, 32'(DEPTH)));
            fill   <= CW'(32'(fill) + 32'(take) - pop_n);
            ovf    <= ovf | drop;
        end
    end
endmodule

// File: rtl/fbq_top.sv
module fbq_top
    import fbq_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int LCW  = $clog2(LANES + 1),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LANES*DW-1:0] grp_data,
    input  logic [LCW-1:0]      grp_cnt,
    output logic                head_vld,
    output logic [DW-1:0]       head_data,
    output logic [CW-1:0]       fill_level,
    output logic                ovf_sticky
);
    logic [LCW-1:0] take;
    logic           drop;
    logic [PW-1:0]  wr_ptr;
    logic [PW-1:0]  rd_ptr;
    logic [DW-1:0]  word;

    fbq_admit #(.LANES(LANES), .DEPTH(DEPTH), .LCW(LCW), .CW(CW)) u_admit (
        .req_cnt (grp_cnt),
        .fill    (fill_level),
        .take    (take),
        .drop    (drop)
    );

    fbq_ctrl #(.DEPTH(DEPTH), .PW(PW), .CW(CW), .LCW(LCW)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .take   (take),
        .drop   (drop),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .fill   (fill_level),
        .ovf    (ovf_sticky)
    );

    fbq_ring #(.LANES(LANES), .DEPTH(DEPTH), .DW(DW), .PW(PW), .LCW(LCW)) u_ring (
        .clk       (clk),
        .wr_base   (wr_ptr),
        .take      (take),
        .lanes     (grp_data),
        .head_idx  (rd_ptr),
        .head_word (word)
    );

    assign head_vld  = (fill_level != '0);
    assign head_data = head_vld ? word : '0;
endmodule

// File: rtl/fbq_chk.sv
module fbq_chk #(
    parameter int LANES = 4,
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    parameter int LCW   = 3,
    parameter int CW    = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [LANES*DW-1:0] grp_data,
    input logic [LCW-1:0]      grp_cnt,
    input logic                head_vld,
    input logic [DW-1:0]       head_data,
    input logic [CW-1:0]       fill_level,
    input logic                ovf_sticky
);
    logic [31:0] eff_c;
    logic [31:0] room_c;

    always_comb begin
        eff_c  = (32'(grp_cnt) > 32'(LANES)) ? 32'(LANES) : 32'(grp_cnt);
        room_c = 32'(DEPTH) - 32'(fill_level);
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (fill_level == '0 && !head_vld && !ovf_sticky));

    a_r2_absent_zero: assert property (@(posedge clk) disable iff (rst)
        !head_vld |-> head_data == '0);

    a_r3_load_first_lane: assert property (@(posedge clk) disable iff (rst)
        (fill_level == '0 && eff_c != 0 && eff_c <= room_c) |=>
        (head_vld && head_data == $past(grp_data[DW-1:0]) && 32'(fill_level) == $past(eff_c)));

    a_r4_append_pop: assert property (@(posedge clk) disable iff (rst)
        (fill_level != '0 && eff_c <= room_c) |=>
        32'(fill_level) == $past(32'(fill_level) + eff_c - 32'd1));

    a_r6_empty_stays_absent: assert property (@(posedge clk) disable iff (rst)
        (fill_level == '0) |-> !head_vld);

    a_r8_sticky_holds: assert property (@(posedge clk) disable iff (rst)
        ovf_sticky |=> ovf_sticky);

    a_r8_sets_on_excess: assert property (@(posedge clk) disable iff (rst)
        (eff_c > room_c) |=> ovf_sticky);

    a_r8_rise_has_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_sticky) |-> $past(eff_c > room_c));

    a_r9_level_bound: assert property (@(posedge clk) disable iff (rst)
        32'(fill_level) <= 32'(DEPTH));
endmodule

bind fbq_top fbq_chk #(
    .LANES(LANES), .DEPTH(DEPTH), .DW(DW), .LCW(LCW), .CW(CW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .grp_data   (grp_data),
    .grp_cnt    (grp_cnt),
    .head_vld   (head_vld),
    .head_data  (head_data),
    .fill_level (fill_level),
    .ovf_sticky (ovf_sticky)
);

// File: tb/sim_fbq_top.sv
`timescale 1ns/1ps
module sim_fbq_top;
    localparam int LANES = 4;
    localparam int DEPTH = 8;
    localparam int DW    = 8;
    localparam int LCW   = $clog2(LANES + 1);
    localparam int CW    = $clog2(DEPTH + 1);

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [LANES*DW-1:0] grp_data = '0;
    logic [LCW-1:0]      grp_cnt  = '0;
    logic                head_vld;
    logic [DW-1:0]       head_data;
    logic [CW-1:0]       fill_level;
    logic                ovf_sticky;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [DW-1:0] exp_q[$];
    bit            exp_ovf = 1'b0;
    int            seed_v  = 1;

    always #2 clk = ~clk;

    fbq_top #(.LANES(LANES), .DEPTH(DEPTH), .DW(DW)) u0 (
        .clk        (clk),
        .rst        (rst),
        .grp_data   (grp_data),
        .grp_cnt    (grp_cnt),
        .head_vld   (head_vld),
        .head_data  (head_data),
        .fill_level (fill_level),
        .ovf_sticky (ovf_sticky)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor side: compare outputs with the head of the expected queue.
    task automatic monitor(input string tag);
        int ev, ed;
        ev = (exp_q.size() != 0) ? 1 : 0;
        ed = (exp_q.size() != 0) ? int'(exp_q[0]) : 0;
        check(int'(head_vld) == ev, tag, "head_vld", int'(head_vld), ev);
        check(int'(head_data) == ed, tag, "head_data", int'(head_data), ed);
        check(int'(fill_level) == exp_q.size(), tag, "fill_level",
              int'(fill_level), exp_q.size());
        check(ovf_sticky == exp_ovf, tag, "ovf_sticky", int'(ovf_sticky), int'(exp_ovf));
    endtask

    // Driver side: offer a group and push what the queue should keep.
    task automatic drive(input int cnt, input string tag);
        int eff, room, acc;
        bit was_empty;
        monitor(tag);
        for (int i = 0; i < LANES; i++) begin
            grp_data[i*DW +: DW] = DW'(seed_v);
            seed_v = (seed_v % 250) + 1;
        end
        grp_cnt = LCW'(cnt);
        eff  = (cnt > LANES) ? LANES : cnt;
        room = DEPTH - exp_q.size();
        acc  = (eff < room) ? eff : room;
        if (eff > room) exp_ovf = 1'b1;
        was_empty = (exp_q.size() == 0);
        for (int i = 0; i < acc; i++) exp_q.push_back(grp_data[i*DW +: DW]);
        if (!was_empty) void'(exp_q.pop_front());
    endtask

    task automatic step(input int cnt, input string tag);
        @(negedge clk);
        drive(cnt, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        grp_cnt = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_q.delete();
        exp_ovf = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state; R2: absent output reads zero
        monitor("R1");
        step(0, "R2");
        step(0, "R2");

        // R6: group into empty queue is not visible before the edge
        step(3, "R3");
        #1;
        check(head_vld == 1'b0, "R6", "head_vld before edge", int'(head_vld), 0);
        // R3 load without pop, R5 lane order during drain
        step(0, "R3");
        step(0, "R5");
        step(0, "R5");
        step(0, "R5");

        // R4: append and pop while non-empty
        step(2, "R4");
        step(4, "R4");
        step(1, "R4");
        step(0, "R4");
        step(3, "R4");

        // R7: count above LANES behaves as LANES
        step(7, "R7");
        step(5, "R7");
        step(6, "R7");
        for (int k = 0; k < 10; k++) step(0, "R5");

        // R8 boundary: reach level 7, then a single word exactly fits
        step(4, "R8");
        step(4, "R8");
        step(1, "R8");
        step(0, "R8");
        // R8: excess dropped, flag sticky through the drain
        step(0, "R9");
        step(4, "R8");
        step(4, "R8");
        step(4, "R8");
        step(2, "R8");
        for (int k = 0; k < 10; k++) step(0, "R8");
        step(0, "R8");

        // R1: reset clears contents and sticky flag mid-run
        step(4, "R1");
        step(4, "R1");
        do_reset();
        monitor("R1");
        step(7, "R3");
        step(0, "R3");
        for (int k = 0; k < 5; k++) step(0, "R5");
        @(negedge clk);
        monitor("R2");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule